// File: doc/BRIEF.md
# Dual-Compare Set/Reset PWM Generator

This block is a timer channel that drives two single-phase PWM pins, A and B, from one up-counter. Each pin has two compare values of its own. A match on the "on" compare moves the pin to its active level, and a match on the "off" compare returns it to its inactive level. Both pins run from the same counter, so the phase between their edges is fixed by the compare values alone. A per-pin polarity bit sets the inactive level and swaps the roles of the two compares. A second counter with its own period feeds two spare compares, C and D. These compares play no part in the waveforms. They set sticky interrupt flags, which combine into one interrupt line.

Software programs the block through a single-cycle write port. Period, the four pin compares and the two polarity bits are written to staging registers. They are copied to the working set only while the channel is disabled, or at the counter wrap. A period already in progress always finishes with the settings it began with. The counters advance only on cycles where the `tick` input is high.

Top module: `twin_edge_pwm`

## Requirements
- R1: After reset, all registers are zero, both counters are at 0, `pwm_a`, `pwm_b` and `irq` are 0.
- R2: While enabled, the main counter advances by one on each clock with `tick` high and holds when `tick` is low. On a tick where it equals the working period, it goes back to 0. Both pins are timed by this one counter.
- R3: With polarity 0, a tick on which the counter equals the pin's "on" compare (A: address 2, B: address 4) drives the pin to 1 at that clock edge. A tick on which it equals the "off" compare (A: address 3, B: address 5) drives the pin to 0. Otherwise the pin holds its value.
- R4: With polarity 1 (control bit 1 for A, bit 2 for B), the "on" match drives the pin to 0 and the "off" match drives it to 1.
- R5: If the "on" and "off" matches of one pin occur on the same tick, the pin goes to its inactive level, which equals its polarity bit.
- R6: While the enable bit (control address 0, bit 0) is 0, the main counter is held at 0. Each pin is driven to its inactive level, taken from the polarity bit as last written.
- R7: Writes to period (address 1), pin compares and polarity bits made while running leave the waveform unchanged until the next main-counter wrap, and take effect from count 0 onward.
- R8: The second counter counts ticks while enabled, from 0 up to its own period (address 8), then returns to 0. It is not staged. A tick on which it equals spare compare C (address 6) or D (address 7) sets flag C or D. A flag stays set until a write of 1 to its bit at address 9 (bit 0 C, bit 1 D). When a set and a clear fall on the same cycle, the set wins.
- R9: `irq` is high exactly when a set flag has its enable bit set (control bit 3 for C, bit 4 for D).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable strobe for both counters |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CNT_W | Write data |
| pwm_a | output | 1 | PWM pin A |
| pwm_b | output | 1 | PWM pin B |
| irq | output | 1 | Combined spare-compare interrupt |

## Verification
A working set that is loaded at the wrong time shows up first as a pin edge at the wrong count. This happens within one period after a running write, long before the next wrap could hide it. A counter that fails to hold on idle ticks, or that wraps one count late, moves every later edge of both pins. The fault therefore appears within one period and grows from there. A flag that fails to stick, or that clears on a matching write, changes `irq` on the very next cycle. The bench compares all three outputs with a behavioural model on every clock.

// File: rtl/twpwm_pkg.sv
package twpwm_pkg;
  localparam int NUM_PINS  = 2;
  localparam int NUM_SPARE = 2;

  localparam logic [3:0] ADR_CTRL  = 4'd0;
  localparam logic [3:0] ADR_PER0  = 4'd1;
  localparam logic [3:0] ADR_A_ON  = 4'd2;
  localparam logic [3:0] ADR_A_OFF = 4'd3;
  localparam logic [3:0] ADR_B_ON  = 4'd4;
  localparam logic [3:0] ADR_B_OFF = 4'd5;
  localparam logic [3:0] ADR_SP_C  = 4'd6;
  localparam logic [3:0] ADR_SP_D  = 4'd7;
  localparam logic [3:0] ADR_PER1  = 4'd8;
  localparam logic [3:0] ADR_FLAG  = 4'd9;

  localparam int CTRL_RUN   = 0;
  localparam int CTRL_POL_A = 1;
  localparam int CTRL_POL_B = 2;
  localparam int CTRL_IEN_C = 3;
  localparam int CTRL_IEN_D = 4;

  // Off match beats on match: a tie lands on the inactive level.
  function automatic logic pin_update(input logic cur, input logic pol,
                                      input logic hit_on, input logic hit_off);
    if (hit_off)     return pol;
    else if (hit_on) return ~pol;
    else             return cur;
  endfunction
endpackage

// File: rtl/twpwm_counter.sv
module twpwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] step(input logic [W-1:0] c, input logic [W-1:0] lim);
    return (c == lim) ? '0 : c + ONE;
  endfunction

  assign wrap = run && tick && (count == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (!run)   count <= '0;
    else if (tick)   count <= step(count, limit);
  end
endmodule

// File: rtl/twpwm_regs.sv
module twpwm_regs import twpwm_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [3:0]                      wr_addr,
  input  logic [CNT_W-1:0]                wr_data,
  input  logic                            wrap0,
  output logic                            run,
  output logic [CNT_W-1:0]                per0_act,
  output logic [CNT_W-1:0]                per1,
  output logic [NUM_PINS-1:0][CNT_W-1:0]  on_act,
  output logic [NUM_PINS-1:0][CNT_W-1:0]  off_act,
  output logic [NUM_PINS-1:0]             pol_act,
  output logic [NUM_PINS-1:0]             pol_idle,
  output logic [NUM_SPARE-1:0][CNT_W-1:0] spare_cmp,
  output logic [NUM_SPARE-1:0]            ien,
  output logic [NUM_SPARE-1:0]            flag_clr
);
  logic [CNT_W-1:0]               per0_stg;
  logic [NUM_PINS-1:0][CNT_W-1:0] on_stg;
  logic [NUM_PINS-1:0][CNT_W-1:0] off_stg;
  logic [NUM_PINS-1:0]            pol_stg;
  logic                           load_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      per0_stg  <= '0;
      per1      <= '0;
      on_stg    <= '0;
      off_stg   <= '0;
      pol_stg   <= '0;
      spare_cmp <= '0;
      ien       <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL: begin
          run        <= wr_data[CTRL_RUN];
          pol_stg[0] <= wr_data[CTRL_POL_A];
          pol_stg[1] <= wr_data[CTRL_POL_B];
          ien[0]     <= wr_data[CTRL_IEN_C];
          ien[1]     <= wr_data[CTRL_IEN_D];
        end
        ADR_PER0:  per0_stg     <= wr_data;
        ADR_A_ON:  on_stg[0]    <= wr_data;
        ADR_A_OFF: off_stg[0]   <= wr_data;
        ADR_B_ON:  on_stg[1]    <= wr_data;
        ADR_B_OFF: off_stg[1]   <= wr_data;
        ADR_SP_C:  spare_cmp[0] <= wr_data;
        ADR_SP_D:  spare_cmp[1] <= wr_data;
        ADR_PER1:  per1         <= wr_data;
        default: ;
      endcase
    end
  end

  // Working set follows staging while idle, then only at a wrap.
  assign load_act = !run || wrap0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per0_act <= '0;
      on_act   <= '0;
      off_act  <= '0;
      pol_act  <= '0;
    end else if (load_act) begin
      per0_act <= per0_stg;
      on_act   <= on_stg;
      off_act  <= off_stg;
      pol_act  <= pol_stg;
    end
  end

  assign pol_idle = pol_stg;
  assign flag_clr = (wr_en && (wr_addr == ADR_FLAG)) ? wr_data[NUM_SPARE-1:0] : '0;
endmodule

// File: rtl/twpwm_pin.sv
module twpwm_pin import twpwm_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] count,
  input  logic [W-1:0] on_val,
  input  logic [W-1:0] off_val,
  input  logic         pol_act,
  input  logic         pol_idle,
  output logic         pin,
  output logic         hit_on,
  output logic         hit_off
);
  assign hit_on  = run && tick && (count == on_val);
  assign hit_off = run && tick && (count == off_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pin <= 1'b0;
    else if (!run) pin <= pol_idle;
    else           pin <= pin_update(pin, pol_act, hit_on, hit_off);
  end
endmodule

// File: rtl/twpwm_spare.sv
module twpwm_spare import twpwm_pkg::*; #(
  parameter int W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        run,
  input  logic                        tick,
  input  logic [W-1:0]                count,
  input  logic [NUM_SPARE-1:0][W-1:0] cmp,
  input  logic [NUM_SPARE-1:0]        clr,
  input  logic [NUM_SPARE-1:0]        ien,
  output logic [NUM_SPARE-1:0]        hit,
  output logic [NUM_SPARE-1:0]        flags,
  output logic                        irq
);
  for (genvar s = 0; s < NUM_SPARE; s++) begin : g_src
    assign hit[s] = run && tick && (count == cmp[s]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[s] <= 1'b0;
      else        flags[s] <= hit[s] || (flags[s] && !clr[s]);
    end
  end

  assign irq = |(flags & ien);
endmodule

// File: rtl/twin_edge_pwm.sv
module twin_edge_pwm import twpwm_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             irq
);
  logic                            run;
  logic [CNT_W-1:0]                cnt0, cnt1;
  logic                            wrap0, wrap1;
  logic [CNT_W-1:0]                per0_act, per1;
  logic [NUM_PINS-1:0][CNT_W-1:0]  on_act, off_act;
  logic [NUM_PINS-1:0]             pol_act, pol_idle;
  logic [NUM_SPARE-1:0][CNT_W-1:0] spare_cmp;
  logic [NUM_SPARE-1:0]            ien, flag_clr, spare_hit, flags;
  logic [NUM_PINS-1:0]             pins, hit_on, hit_off;

  twpwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wrap0(wrap0), .run(run), .per0_act(per0_act), .per1(per1),
    .on_act(on_act), .off_act(off_act), .pol_act(pol_act), .pol_idle(pol_idle),
    .spare_cmp(spare_cmp), .ien(ien), .flag_clr(flag_clr)
  );

  twpwm_counter #(.W(CNT_W)) u_cnt_main (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .limit(per0_act), .count(cnt0), .wrap(wrap0)
  );

  twpwm_counter #(.W(CNT_W)) u_cnt_spare (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .limit(per1), .count(cnt1), .wrap(wrap1)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    twpwm_pin #(.W(CNT_W)) u_pin (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .count(cnt0),
      .on_val(on_act[g]), .off_val(off_act[g]), .pol_act(pol_act[g]),
      .pol_idle(pol_idle[g]), .pin(pins[g]), .hit_on(hit_on[g]), .hit_off(hit_off[g])
    );
  end

  twpwm_spare #(.W(CNT_W)) u_spare (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .count(cnt1),
    .cmp(spare_cmp), .clr(flag_clr), .ien(ien), .hit(spare_hit),
    .flags(flags), .irq(irq)
  );

  assign pwm_a = pins[0];
  assign pwm_b = pins[1];
endmodule

// File: rtl/twpwm_checker.sv
module twpwm_checker #(
  parameter int CNT_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 run,
  input logic                 tick,
  input logic [CNT_W-1:0]     cnt0,
  input logic [CNT_W-1:0]     cnt1,
  input logic                 wrap0,
  input logic                 wrap1,
  input logic [CNT_W-1:0]     per0_act,
  input logic [2*CNT_W-1:0]   on_act,
  input logic [1:0]           pol_act,
  input logic [1:0]           pol_idle,
  input logic [1:0]           hit_on,
  input logic [1:0]           hit_off,
  input logic [1:0]           flags,
  input logic [1:0]           flag_clr,
  input logic                 pwm_a,
  input logic                 irq
);
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap0 |=> (cnt0 == '0)); // R2
  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 <= per0_act)); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt0)); // R2
  AST_ON_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_on[0] && !hit_off[0]) |=> (pwm_a != $past(pol_act[0]))); // R3
  AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_off[0] |=> (pwm_a == $past(pol_act[0]))); // R5
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pwm_a == $past(pol_idle[0]))); // R6
  AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt0 == '0)); // R6
  AST_WORKSET_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap0) |=> $stable(on_act)); // R7
  AST_SPARE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap1 |=> (cnt1 == '0)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !flag_clr[0]) |=> flags[0]); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 2'b00) |-> !irq); // R9
endmodule

bind twin_edge_pwm twpwm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cnt0(cnt0), .cnt1(cnt1),
  .wrap0(wrap0), .wrap1(wrap1), .per0_act(per0_act), .on_act(on_act),
  .pol_act(pol_act), .pol_idle(pol_idle), .hit_on(hit_on), .hit_off(hit_off),
  .flags(flags), .flag_clr(flag_clr), .pwm_a(pwm_a), .irq(irq)
);

// File: tb/twin_edge_pwm_bench.sv
module twin_edge_pwm_bench;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [3:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic pwm_a, pwm_b, irq;

  always #5 clk = ~clk;

  twin_edge_pwm #(.CNT_W(W)) u_twin_edge_pwm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b), .irq(irq)
  );

  int n_checks = 0, n_fail = 0;
  string tag = "R1";
  bit done = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  // Behavioural model, integer state
  int m_run, m_cnt0, m_cnt1, m_per0s, m_per0a, m_per1;
  int m_ons[2], m_offs[2], m_ona[2], m_offa[2], m_pols[2], m_pola[2];
  int m_pin[2], m_sp[2], m_ien[2], m_flag[2];

  always @(posedge clk) begin : model
    int w0, clr;
    if (!rst_n) begin
      m_run = 0; m_cnt0 = 0; m_cnt1 = 0; m_per0s = 0; m_per0a = 0; m_per1 = 0;
      for (int i = 0; i < 2; i++) begin
        m_ons[i] = 0; m_offs[i] = 0; m_ona[i] = 0; m_offa[i] = 0; m_pols[i] = 0;
        m_pola[i] = 0; m_pin[i] = 0; m_sp[i] = 0; m_ien[i] = 0; m_flag[i] = 0;
      end
    end else begin
      w0 = (m_run != 0 && tick && m_cnt0 == m_per0a) ? 1 : 0;
      for (int i = 0; i < 2; i++) begin
        if (m_run == 0) m_pin[i] = m_pols[i];
        else if (tick) begin
          if (m_cnt0 == m_offa[i])     m_pin[i] = m_pola[i];
          else if (m_cnt0 == m_ona[i]) m_pin[i] = 1 - m_pola[i];
        end
        clr = (wr_en && wr_addr == 4'd9 && wr_data[i]) ? 1 : 0;
        if (m_run != 0 && tick && m_cnt1 == m_sp[i]) m_flag[i] = 1;
        else if (clr != 0) m_flag[i] = 0;
      end
      if (m_run == 0) begin m_cnt0 = 0; m_cnt1 = 0; end
      else if (tick) begin
        m_cnt0 = (m_cnt0 == m_per0a) ? 0 : (m_cnt0 + 1) % 256;
        m_cnt1 = (m_cnt1 == m_per1)  ? 0 : (m_cnt1 + 1) % 256;
      end
      if (m_run == 0 || w0 != 0) begin
        m_per0a = m_per0s;
        for (int i = 0; i < 2; i++) begin
          m_ona[i] = m_ons[i]; m_offa[i] = m_offs[i]; m_pola[i] = m_pols[i];
        end
      end
      if (wr_en) begin
        case (int'(wr_addr))
          0: begin
            m_run = wr_data[0]; m_pols[0] = wr_data[1]; m_pols[1] = wr_data[2];
            m_ien[0] = wr_data[3]; m_ien[1] = wr_data[4];
          end
          1: m_per0s = int'(wr_data);
          2: m_ons[0] = int'(wr_data);
          3: m_offs[0] = int'(wr_data);
          4: m_ons[1] = int'(wr_data);
          5: m_offs[1] = int'(wr_data);
          6: m_sp[0] = int'(wr_data);
          7: m_sp[1] = int'(wr_data);
          8: m_per1 = int'(wr_data);
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("pwm_a", int'(pwm_a), m_pin[0]);
      check("pwm_b", int'(pwm_b), m_pin[1]);
      check("irq", int'(irq), (m_flag[0] & m_ien[0]) | (m_flag[1] & m_ien[1]));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cycles(input int n, input bit random_tick);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (random_tick) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tick = lfsr[0];
      end else tick = 1'b1;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    check("reset pwm_a", int'(pwm_a), 0);
    check("reset pwm_b", int'(pwm_b), 0);
    check("reset irq", int'(irq), 0);

    tag = "R3";
    wr(1, 9); wr(2, 2); wr(3, 6); wr(4, 5); wr(5, 8);
    wr(0, 1);
    cycles(30, 1'b0);

    tag = "R2";
    cycles(60, 1'b1);

    tag = "R7";
    tick = 1'b1;
    wr(2, 1); wr(3, 4); wr(1, 5); wr(4, 0); wr(5, 3);
    cycles(40, 1'b0);

    tag = "R6";
    wr(0, 0);
    cycles(5, 1'b0);
    wr(0, 6);
    @(negedge clk);
    check("idle pwm_a", int'(pwm_a), 1);
    check("idle pwm_b", int'(pwm_b), 1);

    tag = "R4";
    wr(0, 7);
    cycles(40, 1'b0);
    cycles(30, 1'b1);

    tag = "R5";
    wr(2, 3); wr(3, 3); wr(4, 2); wr(5, 2);
    cycles(30, 1'b0);

    tag = "R8";
    wr(8, 7); wr(6, 3); wr(7, 5);
    cycles(20, 1'b0);
    wr(9, 1);
    cycles(3, 1'b0);
    wr(9, 3);
    cycles(12, 1'b1);

    tag = "R9";
    wr(0, 7 | 8);
    cycles(10, 1'b0);
    wr(9, 3);
    cycles(2, 1'b0);
    wr(0, 7 | 16);
    cycles(10, 1'b0);
    wr(0, 7 | 24);
    wr(9, 3);
    cycles(4, 1'b0);
    wr(0, 6);
    cycles(4, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL %s watchdog: actual %0d expected %0d", tag, 0, 1);
      summary();
      $finish;
    end
  end
endmodule